// File: doc/BRIEF.md
# Three-Wire Serial Programming Register Slave

This block receives programming words for a radio synthesizer and transmit path over a three-wire serial link made of a serial clock, a data line and an active-low frame enable. All three lines come from outside the system clock domain. Each one passes through a synchronizer, and the serial clock is then edge-detected against a faster system clock. While the frame enable is low, each rising serial clock edge shifts one data bit into a shift register, most significant bit first. When the enable returns high, the bit received last acts as an address. It chooses which of two holding registers takes the shifted contents: a 24-bit channel word or a 14-bit setup word.

The block decodes the stored words into named fields and drives them continuously:

- reference divider choice and divide value
- swallow and main counter values, and the combined loop division ratio
- oscillator select
- modulation filter scale code and filter enable
- charge-pump current code and its signed step offset
- shared demodulator-tune / ramp-level DAC code
- test output select
- transmit power code and its signed level in dBm

A one-cycle strobe marks each update of either word. The analog circuits that use these fields are outside this block.

Top module: `tw_serial_regs`

## Requirements
- R1: Data is sampled on each rising serial clock edge while the enable is low and shifted in most significant bit first; serial clock edges while the enable is high change nothing.
- R2: On the rising edge of the enable, the last bit received selects the target: 1 loads the 23 preceding bits into the channel word, 0 loads the 13 preceding bits into the setup word; the other word is left unchanged.
- R3: Any number of bits may arrive in a frame; leading extra bits are dropped and only the last 24 (channel) or 14 (setup) count. A frame with no clock edges re-applies the shift register's current contents.
- R4: Channel word fields: bit 22 reference select (0 → divide by 6, 1 → divide by 8); bits 21..17 swallow count; bits 16..13 main code, giving main count = 80 + code; bit 12 oscillator select; bits 9..7 filter scale code; bits 2..1 charge-pump code; bit 0 filter enable.
- R5: The loop division ratio output equals 32 × main count + swallow count.
- R6: Charge-pump codes 00, 01, 10 and 11 give signed offsets of −1, 0, +1 and +2 steps.
- R7: Setup word fields: bits 12..11 power code; bits 10..6 the 5-bit DAC code; bits 2..0 test select; bits 5..3 are not used.
- R8: Power codes 00, 01, 10 and 11 give signed levels of −21, −11, −4 and +3 dBm.
- R9: Each word update raises exactly one strobe (channel or setup) for exactly one system clock, and the two strobes are never high together.
- R10: After reset both words are zero: divide by 6, main count 80, ratio 2560, offset −1, level −21 dBm, and both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock (asynchronous) |
| ser_data | input | 1 | Serial data (asynchronous) |
| ser_en_n | input | 1 | Active-low frame enable (asynchronous) |
| ref_sel | output | 1 | Reference divider select |
| ref_div | output | 4 | Reference divide value (6 or 8) |
| swallow_cnt | output | 5 | Swallow counter value |
| main_cnt | output | 7 | Main counter value (base + code) |
| div_ratio | output | 12 | Loop division ratio |
| vco_sel | output | 1 | Oscillator select |
| gf_scale | output | 3 | Modulation filter scale code |
| gf_en | output | 1 | Modulation filter enable |
| cp_code | output | 2 | Charge-pump current code |
| cp_offset | output | 3 | Signed charge-pump step offset |
| dac_code | output | 5 | Demodulator-tune / ramp-level DAC code |
| test_sel | output | 3 | Test output select |
| pa_code | output | 2 | Transmit power code |
| pa_dbm | output | 6 | Signed transmit level in dBm |
| chan_load | output | 1 | One-cycle strobe on channel word update |
| setup_load | output | 1 | One-cycle strobe on setup word update |

## Verification
The bench builds the block with its defaults: two synchronizer stages, main-count base 80 and prescale 32. These values keep every division ratio within 12 bits, so the ratio arithmetic can be checked over the whole range of codes. Serial half periods of eight system clocks leave enough margin for the synchronizer delay that frames of up to 64 bits, with random leading junk, can be checked bit-exact. Directed frames cover every charge-pump and power code, all-ones and all-zeros words, serial clocking while the enable is high, and an empty frame whose re-load shows that the idle clocking left the shift register untouched.

// File: rtl/tw_reg_pkg.sv
// Package: word lengths, field layouts and unpack helpers shared by
// the serial register slave. Assumes the fixed two-word layout.
package tw_reg_pkg;
    localparam int CH_LEN  = 24;          // channel frame incl. address
    localparam int SU_LEN  = 14;          // setup frame incl. address
    localparam int CH_DATA = CH_LEN - 1;
    localparam int SU_DATA = SU_LEN - 1;
    localparam int REF_DIV_LO = 6;
    localparam int REF_DIV_HI = 8;

    typedef struct packed {
        logic       ref_sel;
        logic [4:0] swallow;
        logic [3:0] main_code;
        logic       vco_sel;
        logic [2:0] gf_scale;
        logic [1:0] cp_code;
        logic       gf_en;
    } chan_fields_t;

    typedef struct packed {
        logic [1:0] pa_code;
        logic [4:0] dac_code;
        logic [2:0] test_sel;
    } setup_fields_t;

    // Pull the channel fields from their bit positions.
    function automatic chan_fields_t unpack_chan(input logic [CH_DATA-1:0] w);
        chan_fields_t f;
        f.ref_sel   = w[22];
        f.swallow   = w[21:17];
        f.main_code = w[16:13];
        f.vco_sel   = w[12];
        f.gf_scale  = w[9:7];
        f.cp_code   = w[2:1];
        f.gf_en     = w[0];
        return f;
    endfunction

    // Pull the setup fields from their bit positions.
    function automatic setup_fields_t unpack_setup(input logic [SU_DATA-1:0] w);
        setup_fields_t f;
        f.pa_code  = w[12:11];
        f.dac_code = w[10:6];
        f.test_sel = w[2:0];
        return f;
    endfunction
endpackage

// File: rtl/tw_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous lines.
// Assumes every bit is independent; per-bit reset value is a parameter.
module tw_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Advance one synchronizer stage.
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= d;
                else             chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_frame.sv
// Module: serial frame engine. Detects serial clock rises and the end of
// a frame on already-synchronized lines, shifts data MSB first and loads
// the addressed holding word. Assumes the system clock oversamples the
// serial clock by several cycles per half period.
module tw_frame
    import tw_reg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdat_s,
    input  logic               sen_n_s,
    output logic [CH_DATA-1:0] chan_word,
    output logic [SU_DATA-1:0] setup_word,
    output logic               chan_load,
    output logic               setup_load
);
    logic              sclk_q;
    logic              sen_q;
    logic [CH_LEN-1:0] sr;
    logic              shift_en;
    logic              frame_end;

    assign shift_en  = sclk_s & ~sclk_q & ~sen_n_s;
    assign frame_end = sen_n_s & ~sen_q;

    // Hold previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sen_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            sen_q  <= sen_n_s;
        end
    end

    // Shift one bit in per qualified serial clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr <= '0;
        else if (shift_en) sr <= {sr[CH_LEN-2:0], sdat_s};
    end

    // Load the addressed word and raise its strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_word  <= '0;
            setup_word <= '0;
            chan_load  <= 1'b0;
            setup_load <= 1'b0;
        end else begin
            chan_load  <= 1'b0;
            setup_load <= 1'b0;
            if (frame_end) begin
                if (sr[0]) begin
                    chan_word <= sr[CH_LEN-1:1];
                    chan_load <= 1'b1;
                end else begin
                    setup_word <= sr[SU_LEN-1:1];
                    setup_load <= 1'b1;
                end
            end
        end
    end

    // R1: no shifting while the synchronized enable is high
    a_r1_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        sen_n_s |=> $stable(sr));
    // R2: channel word changes only with its strobe
    a_r2_chan_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_word) |-> chan_load);
    // R2: setup word changes only with its strobe
    a_r2_setup_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(setup_word) |-> setup_load);
    // R9: strobes never together
    a_r9_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chan_load, setup_load}));
    // R9: each strobe lasts a single cycle
    a_r9_chan_single: assert property (@(posedge clk) disable iff (!rst_n)
        chan_load |=> !chan_load);
    a_r9_setup_single: assert property (@(posedge clk) disable iff (!rst_n)
        setup_load |=> !setup_load);
endmodule

// File: rtl/tw_decode.sv
// Module: field decoder. Turns the stored words into counter values, the
// division ratio and signed offsets. Purely combinational.
module tw_decode
    import tw_reg_pkg::*;
#(
    parameter int MAIN_BASE = 80,
    parameter int PRESCALE  = 32,
    parameter int MAIN_W    = 7,
    parameter int RATIO_W   = 12
) (
    input  logic [CH_DATA-1:0]  chan_word,
    input  logic [SU_DATA-1:0]  setup_word,
    output logic                ref_sel,
    output logic [3:0]          ref_div,
    output logic [4:0]          swallow_cnt,
    output logic [MAIN_W-1:0]   main_cnt,
    output logic [RATIO_W-1:0]  div_ratio,
    output logic                vco_sel,
    output logic [2:0]          gf_scale,
    output logic                gf_en,
    output logic [1:0]          cp_code,
    output logic signed [2:0]   cp_offset,
    output logic [4:0]          dac_code,
    output logic [2:0]          test_sel,
    output logic [1:0]          pa_code,
    output logic signed [5:0]   pa_dbm
);
    chan_fields_t  cf;
    setup_fields_t sf;

    assign cf = unpack_chan(chan_word);
    assign sf = unpack_setup(setup_word);

    // Channel-side values and division ratio.
    always_comb begin
        ref_sel     = cf.ref_sel;
        ref_div     = cf.ref_sel ? 4'(REF_DIV_HI) : 4'(REF_DIV_LO);
        swallow_cnt = cf.swallow;
        main_cnt    = MAIN_W'(MAIN_BASE) + MAIN_W'(cf.main_code);
        div_ratio   = RATIO_W'(PRESCALE) * RATIO_W'(main_cnt) + RATIO_W'(cf.swallow);
        vco_sel     = cf.vco_sel;
        gf_scale    = cf.gf_scale;
        gf_en       = cf.gf_en;
        cp_code     = cf.cp_code;
        cp_offset   = $signed({1'b0, cf.cp_code}) - 3'sd1;
    end

    // Setup-side values and power level table.
    always_comb begin
        dac_code = sf.dac_code;
        test_sel = sf.test_sel;
        pa_code  = sf.pa_code;
        case (sf.pa_code)
            2'b00:   pa_dbm = -6'sd21;
            2'b01:   pa_dbm = -6'sd11;
            2'b10:   pa_dbm = -6'sd4;
            default: pa_dbm = 6'sd3;
        endcase
    end
endmodule

// File: rtl/tw_serial_regs.sv
// Module: top of the three-wire serial programming slave. Synchronizes
// the serial lines, runs the frame engine and decodes both words.
// Assumes serial half periods span several system clocks.
module tw_serial_regs
    import tw_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAIN_BASE   = 80,
    parameter int PRESCALE    = 32,
    localparam int MAIN_W     = $clog2(MAIN_BASE + 16),
    localparam int RATIO_W    = $clog2(PRESCALE * (MAIN_BASE + 16))
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk,
    input  logic                ser_data,
    input  logic                ser_en_n,
    output logic                ref_sel,
    output logic [3:0]          ref_div,
    output logic [4:0]          swallow_cnt,
    output logic [MAIN_W-1:0]   main_cnt,
    output logic [RATIO_W-1:0]  div_ratio,
    output logic                vco_sel,
    output logic [2:0]          gf_scale,
    output logic                gf_en,
    output logic [1:0]          cp_code,
    output logic signed [2:0]   cp_offset,
    output logic [4:0]          dac_code,
    output logic [2:0]          test_sel,
    output logic [1:0]          pa_code,
    output logic signed [5:0]   pa_dbm,
    output logic                chan_load,
    output logic                setup_load
);
    logic [2:0]         lines_s;
    logic [CH_DATA-1:0] chan_word;
    logic [SU_DATA-1:0] setup_word;

    tw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_en_n, ser_data, ser_clk}),
        .q     (lines_s)
    );

    tw_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (lines_s[0]),
        .sdat_s     (lines_s[1]),
        .sen_n_s    (lines_s[2]),
        .chan_word  (chan_word),
        .setup_word (setup_word),
        .chan_load  (chan_load),
        .setup_load (setup_load)
    );

    tw_decode #(.MAIN_BASE(MAIN_BASE), .PRESCALE(PRESCALE),
                .MAIN_W(MAIN_W), .RATIO_W(RATIO_W)) u_decode (
        .chan_word   (chan_word),
        .setup_word  (setup_word),
        .ref_sel     (ref_sel),
        .ref_div     (ref_div),
        .swallow_cnt (swallow_cnt),
        .main_cnt    (main_cnt),
        .div_ratio   (div_ratio),
        .vco_sel     (vco_sel),
        .gf_scale    (gf_scale),
        .gf_en       (gf_en),
        .cp_code     (cp_code),
        .cp_offset   (cp_offset),
        .dac_code    (dac_code),
        .test_sel    (test_sel),
        .pa_code     (pa_code),
        .pa_dbm      (pa_dbm)
    );

    // R4: reference divide is one of the two allowed values
    a_r4_ref_div_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_div == 4'(REF_DIV_LO)) || (ref_div == 4'(REF_DIV_HI)));
    // R5: ratio never below the prescaled base
    a_r5_ratio_floor: assert property (@(posedge clk) disable iff (!rst_n)
        div_ratio >= RATIO_W'(PRESCALE * MAIN_BASE));
    // R6: offset stays within -1..+2
    a_r6_cp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_offset >= -3'sd1) && (cp_offset <= 3'sd2));
    // R8: the top power code yields a positive level
    a_r8_pa_top: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_code == 2'b11) |-> (pa_dbm > 6'sd0));
endmodule

// File: tb/tw_serial_regs_tb.sv
module tw_serial_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 8;
    localparam int WDOG_CYC   = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_en_n = 1'b1;
    logic ref_sel, vco_sel, gf_en, chan_load, setup_load;
    logic [3:0] ref_div;
    logic [4:0] swallow_cnt, dac_code;
    logic [6:0] main_cnt;
    logic [11:0] div_ratio;
    logic [2:0] gf_scale, test_sel;
    logic [1:0] cp_code, pa_code;
    logic signed [2:0] cp_offset;
    logic signed [5:0] pa_dbm;

    tw_serial_regs u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en_n(ser_en_n), .ref_sel(ref_sel), .ref_div(ref_div),
        .swallow_cnt(swallow_cnt), .main_cnt(main_cnt), .div_ratio(div_ratio),
        .vco_sel(vco_sel), .gf_scale(gf_scale), .gf_en(gf_en),
        .cp_code(cp_code), .cp_offset(cp_offset), .dac_code(dac_code),
        .test_sel(test_sel), .pa_code(pa_code), .pa_dbm(pa_dbm),
        .chan_load(chan_load), .setup_load(setup_load)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    int n_chan = 0, n_setup = 0, n_both = 0, strobe_run = 0, max_run = 0;
    bit done = 0;
    logic [22:0] m_chan = '0;
    logic [12:0] m_setup = '0;

    // Strobe monitor: counts pulses and the longest high run.
    always @(posedge clk) begin
        if (chan_load) n_chan++;
        if (setup_load) n_setup++;
        if (chan_load && setup_load) n_both++;
        if (chan_load || setup_load) strobe_run++; else strobe_run = 0;
        if (strobe_run > max_run) max_run = strobe_run;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_dbm(input logic [1:0] c);
        case (c)
            2'b00: return -21;
            2'b01: return -11;
            2'b10: return -4;
            default: return 3;
        endcase
    endfunction

    // Compare every output with values computed from the model words.
    task automatic check_all(input string tag);
        int mc;
        mc = 80 + int'(m_chan[16:13]);
        chk({tag, " R4 ref_sel"}, int'(ref_sel), int'(m_chan[22]));
        chk({tag, " R4 ref_div"}, int'(ref_div), m_chan[22] ? 8 : 6);
        chk({tag, " R4 swallow"}, int'(swallow_cnt), int'(m_chan[21:17]));
        chk({tag, " R4 main"}, int'(main_cnt), mc);
        chk({tag, " R5 ratio"}, int'(div_ratio), 32 * mc + int'(m_chan[21:17]));
        chk({tag, " R4 vco"}, int'(vco_sel), int'(m_chan[12]));
        chk({tag, " R4 scale"}, int'(gf_scale), int'(m_chan[9:7]));
        chk({tag, " R4 gf_en"}, int'(gf_en), int'(m_chan[0]));
        chk({tag, " R4 cp_code"}, int'(cp_code), int'(m_chan[2:1]));
        chk({tag, " R6 cp_offset"}, int'(cp_offset), int'(m_chan[2:1]) - 1);
        chk({tag, " R7 pa_code"}, int'(pa_code), int'(m_setup[12:11]));
        chk({tag, " R7 dac"}, int'(dac_code), int'(m_setup[10:6]));
        chk({tag, " R7 test"}, int'(test_sel), int'(m_setup[2:0]));
        chk({tag, " R8 pa_dbm"}, int'(pa_dbm), exp_dbm(m_setup[12:11]));
    endtask

    // Drive one frame of n bits, MSB first, then close it.
    task automatic send(input logic [63:0] bits, input int n);
        ser_en_n = 1'b0;
        idle(25);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            idle(HALF_SCK);
            ser_clk = 1'b1;
            idle(HALF_SCK);
            ser_clk = 1'b0;
        end
        idle(HALF_SCK);
        ser_en_n = 1'b1;
        idle(30);
    endtask

    // Frame for either word with `lead` random junk bits in front.
    task automatic frame(input bit is_chan, input logic [22:0] payload, input int lead,
                         input string tag);
        logic [63:0] b;
        int len, c0, s0;
        len = is_chan ? 24 : 14;
        b = {$urandom, $urandom};
        b = b << len;
        if (is_chan) b[23:0] = {payload, 1'b1};
        else         b[13:0] = {payload[12:0], 1'b0};
        c0 = n_chan; s0 = n_setup;
        send(b, len + lead);
        if (is_chan) m_chan = payload; else m_setup = payload[12:0];
        chk({tag, " R2 R9 chan strobes"}, n_chan - c0, is_chan ? 1 : 0);
        chk({tag, " R2 R9 setup strobes"}, n_setup - s0, is_chan ? 0 : 1);
        check_all(tag);
    endtask

    initial begin
        int c0, s0;
        void'($urandom(32'd20240611));
        idle(5);
        rst_n = 1'b1;
        idle(10);
        // R10: reset state
        chk("R10 chan_load", int'(chan_load), 0);
        chk("R10 setup_load", int'(setup_load), 0);
        chk("R10 ratio", int'(div_ratio), 2560);
        chk("R10 pa_dbm", int'(pa_dbm), -21);
        check_all("R10");

        // Directed: extremes and every code (R1 R4 R6 R7 R8)
        frame(1, 23'h7FFFFF, 0, "R1 all-ones chan");
        frame(0, 23'h001FFF, 0, "R7 all-ones setup");
        frame(1, 23'h000000, 0, "R4 zero chan");
        for (int c = 0; c < 4; c++) begin
            frame(1, 23'(c << 1) | 23'h2AA001, 0, "R6 cp sweep");
            frame(0, 23'(c << 11) | 23'h00015, 0, "R8 pa sweep");
        end
        // R3: long junk in front
        frame(1, 23'h5A3C81, 40, "R3 long lead chan");
        frame(0, 23'h0012C5, 50, "R3 long lead setup");

        // R1 R3: clocking while enable high is ignored; an empty frame then
        // re-applies the last shifted setup word unchanged.
        c0 = n_chan; s0 = n_setup;
        ser_data = 1'b1;
        for (int i = 0; i < 12; i++) begin
            idle(HALF_SCK); ser_clk = 1'b1; idle(HALF_SCK); ser_clk = 1'b0;
        end
        idle(20);
        chk("R1 idle clocks chan strobes", n_chan - c0, 0);
        chk("R1 idle clocks setup strobes", n_setup - s0, 0);
        check_all("R1 idle clocks");
        send(64'd0, 0);
        chk("R3 empty frame chan strobes", n_chan - c0, 0);
        chk("R3 empty frame setup strobes", n_setup - s0, 1);
        check_all("R3 empty frame");

        // Random frames (R2 R3 R4 R5 R7)
        for (int k = 0; k < 60; k++) begin
            frame(1'($urandom), 23'($urandom), int'($urandom % 12), "R2 random");
        end

        // R9: pulse shape over the whole run
        chk("R9 max strobe run", max_run, 1);
        chk("R9 both strobes", n_both, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", WDOG_CYC, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule